// File: doc/BRIEF.md
# Flag-Setting Integer ALU

This block is the arithmetic stage of a simple integer datapath. It takes two operands, passes the second one through a barrel shifter (logical left or arithmetic right, by 0 to DATA_W-1 bits), and then adds, subtracts, reverse-subtracts, compares, compares against the negated operand, or forms the low word of the product. The result and a write enable are produced combinationally in the same cycle as the inputs. The enable tells the surrounding pipeline whether the result belongs in a destination register.

Four condition flags (negative, zero, carry, overflow) are held in a register and update on the rising clock edge. Arithmetic operations touch the flags only when the set-flags input is high. The two compare operations always update all four flags and never request a write. A flag-setting multiply refreshes only negative and zero. Idle cycles are made by driving one of the two reserved opcodes.

Top module: `flag_alu`

## Requirements
- R1: Opcode 0 (add) gives result_o = a_i + op2 modulo 2^DATA_W with wr_en_o = 1, where op2 is b_i after the shift selected by shift_type_i and shamt_i.
- R2: Opcode 1 (subtract) gives a_i - op2 and opcode 2 (reverse subtract) gives op2 - a_i, both modulo 2^DATA_W with wr_en_o = 1.
- R3: shift_type_i = 0 shifts b_i left by shamt_i, filling with zeros. shift_type_i = 1 shifts it right by shamt_i, copying the sign bit. A shamt_i of 0 passes b_i unchanged.
- R4: Opcode 5 (multiply) gives the low DATA_W bits of a_i * op2 with wr_en_o = 1.
- R5: Opcode 3 (compare, a_i - op2) and opcode 4 (compare-negative, a_i + op2) drive the computed value on result_o but hold wr_en_o = 0. They update all four flags whatever set_flags_i is.
- R6: When set_flags_i is 0, opcodes 0, 1, 2 and 5 leave all four flags unchanged. Opcodes 6 and 7 are reserved: they give result_o = 0 and wr_en_o = 0, and leave the flags unchanged whatever set_flags_i is.
- R7: An updated N flag equals bit DATA_W-1 of the result and an updated Z flag is 1 exactly when the result is all zeros. Flag outputs change on the rising edge that follows the operation.
- R8: On a flag-setting add or compare-negative, C is the unsigned carry out of the top bit and V is 1 when the signed sum overflows.
- R9: On a flag-setting subtract, reverse subtract or compare, C is 1 when no borrow occurs (minuend >= subtrahend, unsigned) and 0 otherwise. V is 1 on signed overflow.
- R10: A flag-setting multiply updates N and Z from the low product word and leaves C and V at their previous values.
- R11: A synchronous active-high reset clears all four flags on the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the flag register |
| op_i | input | 3 | Operation code (0 add, 1 sub, 2 reverse sub, 3 compare, 4 compare-negative, 5 multiply, 6/7 reserved) |
| set_flags_i | input | 1 | Request a flag update for arithmetic and multiply operations |
| a_i | input | DATA_W | First operand |
| b_i | input | DATA_W | Second operand before shifting |
| shift_type_i | input | 1 | 0 logical left, 1 arithmetic right |
| shamt_i | input | $clog2(DATA_W) | Shift amount for the second operand |
| result_o | output | DATA_W | Combinational result |
| wr_en_o | output | 1 | Result should be written to a destination |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |
| flag_c_o | output | 1 | Carry / no-borrow flag |
| flag_v_o | output | 1 | Signed overflow flag |

## Verification
Two things can happen in one cycle here: a flag-setting multiply writes fresh N and Z, and the C and V left by an earlier add are kept in the same edge. This is provoked by an add that overflows both ways, setting C and V, followed at once by a flag-setting multiply with a negative product. It is judged by checking that N and Z follow the product while C and V still read 1. Shifted operands are also combined with carry and overflow cases, so the shifter and the flag logic act on the same operation. Each scheduled item is checked against a bench-side reference model after the edge.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

   typedef enum logic [2:0] {
      OP_ADD  = 3'd0,
      OP_SUB  = 3'd1,
      OP_RSB  = 3'd2,
      OP_CMP  = 3'd3,
      OP_CMN  = 3'd4,
      OP_MUL  = 3'd5,
      OP_RSV6 = 3'd6,
      OP_RSV7 = 3'd7
   } alu_op_e;

   typedef enum logic {
      SH_LSL = 1'b0,
      SH_ASR = 1'b1
   } shift_kind_e;

   typedef struct packed {
      logic n;
      logic z;
      logic c;
      logic v;
   } cond_flags_t;

endpackage

// File: rtl/alu_op2_shift.sv
module alu_op2_shift #(
   parameter int DATA_W = 32,
   localparam int AMT_W = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] din_i,
   input  logic              arith_i,
   input  logic [AMT_W-1:0]  amt_i,
   output logic [DATA_W-1:0] dout_o
);

   generate
      if ((DATA_W & (DATA_W - 1)) != 0 || DATA_W < 8) begin : g_bad_width
         $error("alu_op2_shift: DATA_W must be a power of two, at least 8");
      end
   endgenerate

   logic [DATA_W-1:0] stage [0:AMT_W];

   assign stage[0] = din_i;

   // one stage per amount bit: stage k moves by 2**k
   generate
      for (genvar k = 0; k < AMT_W; k++) begin : g_stage
         localparam int DIST = 1 << k;
         logic [DATA_W-1:0] moved;
         always_comb begin
            if (arith_i)
               moved = {{DIST{stage[k][DATA_W-1]}}, stage[k][DATA_W-1:DIST]};
            else
               moved = {stage[k][DATA_W-1-DIST:0], {DIST{1'b0}}};
         end
         assign stage[k+1] = amt_i[k] ? moved : stage[k];
      end
   endgenerate

   assign dout_o = stage[AMT_W];

endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] lhs_i,
   input  logic [DATA_W-1:0] rhs_i,
   input  logic              sub_i,
   output logic [DATA_W-1:0] sum_o,
   output logic              carry_o,
   output logic              ovf_o
);

   localparam int EXT_W = DATA_W + 1;

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("alu_addsub: DATA_W must be at least 2");
      end
   endgenerate

   logic [DATA_W-1:0] rhs_eff;
   logic [EXT_W-1:0]  wide;

   // subtraction is lhs + ~rhs + 1, so carry out means "no borrow"
   assign rhs_eff = sub_i ? ~rhs_i : rhs_i;
   assign wide    = {1'b0, lhs_i} + {1'b0, rhs_eff} + EXT_W'(sub_i);
   assign sum_o   = wide[DATA_W-1:0];
   assign carry_o = wide[DATA_W];
   assign ovf_o   = (lhs_i[DATA_W-1] == rhs_eff[DATA_W-1]) &&
                    (sum_o[DATA_W-1] != lhs_i[DATA_W-1]);

   always_comb begin
      if (!sub_i) begin
         // R8
         add_carry_chk: assert (carry_o == (sum_o < lhs_i));
      end else begin
         // R9
         sub_carry_chk: assert (carry_o == (lhs_i >= rhs_i));
      end
   end

endmodule

// File: rtl/alu_mul_lo.sv
module alu_mul_lo #(
   parameter int DATA_W    = 32,
   parameter int MUL_STYLE = 0   // 0: native operator, 1: shift-add array
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   output logic [DATA_W-1:0] prod_o
);

   generate
      if (MUL_STYLE != 0 && MUL_STYLE != 1) begin : g_bad_style
         $error("alu_mul_lo: MUL_STYLE must be 0 or 1");
      end

      if (MUL_STYLE == 0) begin : g_native
         assign prod_o = a_i * b_i;
      end else begin : g_array
         logic [DATA_W-1:0] acc [0:DATA_W];
         assign acc[0] = '0;
         for (genvar i = 0; i < DATA_W; i++) begin : g_row
            assign acc[i+1] = acc[i] + (b_i[i] ? (a_i << i) : '0);
         end
         assign prod_o = acc[DATA_W];
      end
   endgenerate

endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
   import flag_alu_pkg::*;
(
   input  logic        clk,
   input  logic        rst,
   input  logic        upd_nz_i,
   input  logic        upd_cv_i,
   input  cond_flags_t nxt_i,
   output cond_flags_t q_o
);

   always_ff @(posedge clk) begin
      if (rst) begin
         q_o <= '0;
      end else begin
         if (upd_nz_i) begin
            q_o.n <= nxt_i.n;
            q_o.z <= nxt_i.z;
         end
         if (upd_cv_i) begin
            q_o.c <= nxt_i.c;
            q_o.v <= nxt_i.v;
         end
      end
   end

endmodule

// File: rtl/flag_alu.sv
module flag_alu
   import flag_alu_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int MUL_STYLE = 0,
   localparam int AMT_W    = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [2:0]        op_i,
   input  logic              set_flags_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              shift_type_i,
   input  logic [AMT_W-1:0]  shamt_i,
   output logic [DATA_W-1:0] result_o,
   output logic              wr_en_o,
   output logic              flag_n_o,
   output logic              flag_z_o,
   output logic              flag_c_o,
   output logic              flag_v_o
);

   generate
      if ((DATA_W & (DATA_W - 1)) != 0 || DATA_W < 8) begin : g_bad_width
         $error("flag_alu: DATA_W must be a power of two, at least 8");
      end
   endgenerate

   alu_op_e           op;
   logic [DATA_W-1:0] op2;
   logic [DATA_W-1:0] lhs, rhs, sum, prod;
   logic              do_sub, carry, ovf;
   logic              is_cmp, is_arith;
   logic              upd_nz, upd_cv;
   cond_flags_t       nxt, flags;

   assign op = alu_op_e'(op_i);

   alu_op2_shift #(.DATA_W(DATA_W)) u_shift (
      .din_i   (b_i),
      .arith_i (shift_type_i == SH_ASR),
      .amt_i   (shamt_i),
      .dout_o  (op2)
   );

   always_comb begin
      lhs    = a_i;
      rhs    = op2;
      do_sub = 1'b0;
      unique case (op)
         OP_SUB, OP_CMP: do_sub = 1'b1;
         OP_RSB: begin
            lhs    = op2;
            rhs    = a_i;
            do_sub = 1'b1;
         end
         default: ;
      endcase
   end

   alu_addsub #(.DATA_W(DATA_W)) u_addsub (
      .lhs_i   (lhs),
      .rhs_i   (rhs),
      .sub_i   (do_sub),
      .sum_o   (sum),
      .carry_o (carry),
      .ovf_o   (ovf)
   );

   alu_mul_lo #(.DATA_W(DATA_W), .MUL_STYLE(MUL_STYLE)) u_mul (
      .a_i    (a_i),
      .b_i    (op2),
      .prod_o (prod)
   );

   assign is_cmp   = (op == OP_CMP) || (op == OP_CMN);
   assign is_arith = (op == OP_ADD) || (op == OP_SUB) || (op == OP_RSB);

   always_comb begin
      if (op == OP_MUL)
         result_o = prod;
      else if (is_arith || is_cmp)
         result_o = sum;
      else
         result_o = '0;
   end

   assign wr_en_o = is_arith || (op == OP_MUL);
   assign upd_nz  = is_cmp || (set_flags_i && (is_arith || op == OP_MUL));
   assign upd_cv  = is_cmp || (set_flags_i && is_arith);

   assign nxt.n = result_o[DATA_W-1];
   assign nxt.z = (result_o == '0);
   assign nxt.c = carry;
   assign nxt.v = ovf;

   alu_flag_reg u_flags (
      .clk      (clk),
      .rst      (rst),
      .upd_nz_i (upd_nz),
      .upd_cv_i (upd_cv),
      .nxt_i    (nxt),
      .q_o      (flags)
   );

   assign flag_n_o = flags.n;
   assign flag_z_o = flags.z;
   assign flag_c_o = flags.c;
   assign flag_v_o = flags.v;

   // R5
   cmp_no_write_chk: assert property (@(posedge clk) disable iff (rst)
      (op_i == 3'd3 || op_i == 3'd4) |-> !wr_en_o);

   // R6
   flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
      ((!set_flags_i && op_i != 3'd3 && op_i != 3'd4) || op_i >= 3'd6)
      |=> $stable({flag_n_o, flag_z_o, flag_c_o, flag_v_o}));

   // R7
   nz_follow_chk: assert property (@(posedge clk) disable iff (rst)
      (op_i == 3'd3 || op_i == 3'd4 || (set_flags_i && op_i <= 3'd5))
      |=> (flag_z_o == $past(result_o == '0)) &&
          (flag_n_o == $past(result_o[DATA_W-1])));

   // R10
   mul_cv_keep_chk: assert property (@(posedge clk) disable iff (rst)
      (op_i == 3'd5) |=> $stable({flag_c_o, flag_v_o}));

endmodule

// File: tb/flag_alu_tb.sv
module flag_alu_tb;

   localparam int W  = 32;
   localparam int AW = $clog2(W);

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [2:0]    op_i = 3'd6;
   logic          set_flags_i = 1'b0;
   logic [W-1:0]  a_i = '0;
   logic [W-1:0]  b_i = '0;
   logic          shift_type_i = 1'b0;
   logic [AW-1:0] shamt_i = '0;
   logic [W-1:0]  result_o;
   logic          wr_en_o, flag_n_o, flag_z_o, flag_c_o, flag_v_o;

   always #2 clk = ~clk;

   flag_alu #(.DATA_W(W)) u_dut (
      .clk, .rst, .op_i, .set_flags_i, .a_i, .b_i, .shift_type_i, .shamt_i,
      .result_o, .wr_en_o, .flag_n_o, .flag_z_o, .flag_c_o, .flag_v_o
   );

   typedef struct {
      logic [W-1:0] res;
      logic         wr;
      logic [3:0]   flg;
      string        tag;
   } exp_t;

   exp_t       sb_q[$];
   int         checks = 0;
   int         errors = 0;
   logic [3:0] m_flg = 4'b0;   // model flags {n,z,c,v}

   task automatic check(input string tag, input string what,
                        input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // monitor: compare as the design produces results
   always @(posedge clk) begin
      #1;
      if (!rst && sb_q.size() > 0) begin
         exp_t e;
         e = sb_q.pop_front();
         check(e.tag, "result", result_o, e.res);
         check(e.tag, "wr_en", W'(wr_en_o), W'(e.wr));
         check(e.tag, "flags", W'({flag_n_o, flag_z_o, flag_c_o, flag_v_o}), W'(e.flg));
      end
   end

   // driver: apply one operation and schedule its expectation
   task automatic issue(input string tag, input logic [2:0] op, input logic sf,
                        input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic st, input int sh);
      logic [W-1:0] o2, res;
      logic         wr, c, v;
      longint       sa, so, wide;
      exp_t         e;
      @(negedge clk);
      op_i = op; set_flags_i = sf; a_i = a; b_i = b;
      shift_type_i = st; shamt_i = AW'(sh);
      o2 = st ? W'($signed(b) >>> sh) : (b << sh);
      sa = longint'($signed(a));
      so = longint'($signed(o2));
      res = '0; wr = 1'b0; c = m_flg[1]; v = m_flg[0];
      case (op)
         3'd0, 3'd4: begin
            res = a + o2; wr = (op == 3'd0);
            c = ({1'b0, a} + {1'b0, o2}) > {1'b0, {W{1'b1}}};
            wide = sa + so; v = (wide > 64'sd2147483647) || (wide < -64'sd2147483648);
         end
         3'd1, 3'd3: begin
            res = a - o2; wr = (op == 3'd1);
            c = (a >= o2);
            wide = sa - so; v = (wide > 64'sd2147483647) || (wide < -64'sd2147483648);
         end
         3'd2: begin
            res = o2 - a; wr = 1'b1;
            c = (o2 >= a);
            wide = so - sa; v = (wide > 64'sd2147483647) || (wide < -64'sd2147483648);
         end
         3'd5: begin
            res = W'(longint'(a) * longint'(o2)); wr = 1'b1;
         end
         default: ;
      endcase
      if (op == 3'd3 || op == 3'd4 || (sf && op <= 3'd2))
         m_flg = {res[W-1], res == '0, c, v};
      else if (sf && op == 3'd5)
         m_flg = {res[W-1], res == '0, m_flg[1], m_flg[0]};
      e.res = res; e.wr = wr; e.flg = m_flg; e.tag = tag;
      sb_q.push_back(e);
   endtask

   task automatic drain();
      @(negedge clk);
      op_i = 3'd6; set_flags_i = 1'b0;
      while (sb_q.size() > 0) @(negedge clk);
   endtask

   task automatic do_reset(input string tag);
      drain();
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      m_flg = 4'b0;
      check(tag, "flags after reset",
            W'({flag_n_o, flag_z_o, flag_c_o, flag_v_o}), W'(0));
   endtask

   initial begin
      #(4ns * 200000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      do_reset("R11");

      issue("R1_R6", 3'd0, 1'b0, 32'd5, 32'd7, 1'b0, 0);
      issue("R8", 3'd0, 1'b1, 32'hFFFF_FFFF, 32'd1, 1'b0, 0);
      issue("R8", 3'd0, 1'b1, 32'h7FFF_FFFF, 32'd1, 1'b0, 0);
      issue("R8", 3'd0, 1'b1, 32'h8000_0000, 32'h8000_0000, 1'b0, 0);
      // R10: N,Z from product while C,V from the add above stay set
      issue("R10", 3'd5, 1'b1, 32'd3, 32'hFFFF_FFFE, 1'b0, 0);
      issue("R9", 3'd1, 1'b1, 32'd10, 32'd3, 1'b0, 0);
      issue("R9", 3'd1, 1'b1, 32'd3, 32'd10, 1'b0, 0);
      issue("R9", 3'd1, 1'b1, 32'h8000_0000, 32'd1, 1'b0, 0);
      issue("R2", 3'd2, 1'b1, 32'd3, 32'd10, 1'b0, 0);
      issue("R5", 3'd3, 1'b0, 32'd5, 32'd5, 1'b0, 0);
      issue("R5", 3'd4, 1'b0, 32'hFFFF_FFFF, 32'd1, 1'b0, 0);
      issue("R6", 3'd1, 1'b0, 32'd1, 32'd2, 1'b0, 0);
      issue("R6", 3'd6, 1'b1, 32'd9, 32'd9, 1'b0, 0);
      issue("R6", 3'd7, 1'b1, 32'd0, 32'd0, 1'b1, 3);
      issue("R3", 3'd0, 1'b1, 32'd0, 32'd1, 1'b0, 31);
      issue("R3", 3'd0, 1'b1, 32'd0, 32'h8000_0000, 1'b1, 31);
      issue("R3", 3'd0, 1'b0, 32'd0, 32'h4000_0000, 1'b1, 4);
      issue("R3", 3'd1, 1'b1, 32'h7FFF_FFFF, 32'h8000_0000, 1'b1, 1);
      issue("R4", 3'd5, 1'b1, 32'h0001_0000, 32'h0001_0000, 1'b0, 0);
      issue("R4", 3'd5, 1'b0, 32'h1234_5678, 32'd3, 1'b0, 2);
      issue("R7", 3'd3, 1'b1, 32'd0, 32'd1, 1'b0, 0);

      for (int i = 0; i < 300; i++) begin
         issue("R7_mix", 3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
               $urandom(), $urandom(), 1'($urandom_range(0, 1)),
               int'($urandom_range(0, W - 1)));
      end

      issue("R11_pre", 3'd3, 1'b0, 32'd0, 32'd1, 1'b0, 0);
      do_reset("R11");
      issue("R1", 3'd0, 1'b0, 32'd100, 32'd23, 1'b0, 2);

      drain();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule